// File: doc/BRIEF.md
# Write-merging store buffer with least-recently-used retirement

The block sits between a processor's store path and slow main memory. It keeps up to eight 64-bit words with their aligned addresses. A store to a word that is already held is folded into that entry in place. A store to a new word takes a free slot, and when every slot is occupied it pushes the least recently used word out to memory and reuses that slot. Recency is kept as an ordered list of slot indices. Both a merge and an allocation move the touched slot to the most-recent end of that list.

The block also arbitrates data-cache refills. When a load misses in the data cache, its aligned address is compared against the held words. If none matches, the refill is granted straight away and the buffer is left alone. If one matches, every held word is first written to memory, oldest first, and only then is the refill granted. A load that hits in the data cache is ignored. A refill grant is never given while a memory write is still outstanding.

Top module: `wb_merge_lru`

## Requirements
- R1: After a synchronous reset the buffer is empty, `st_ready` is 1, and both `mem_valid` and `ld_grant` are 0.
- R2: A store whose address bits [AW-1:3] equal those of a held word updates only the bytes whose `st_be` bit is set, ORs `st_be` into that word's byte mask, uses no new slot and causes no memory write.
- R3: A store to a word that is not held, while fewer than 8 words are held, takes a free slot. Its enabled bytes are written and its other bytes become zero. No memory write is caused.
- R4: A store to a word that is not held, while 8 words are held, writes the least recently used word to memory and reuses its slot. The write carries `mem_addr` = word address with bits [2:0] zero, the stored data, and the accumulated byte mask.
- R5: Recency order is refreshed on every merge and every allocation. A merged word therefore becomes most recently used and is not the next one evicted.
- R6: A load with `ld_valid`=1 and `ld_dc_hit`=0 whose word is held causes all held words to be written to memory in least-to-most recently used order. After the last write, `ld_grant` pulses and the buffer is empty.
- R7: A load with `ld_valid`=1 and `ld_dc_hit`=0 whose word is not held, presented while no write is outstanding, leaves the buffer unchanged. `ld_grant` is then 1 for exactly one cycle, in the cycle after the request is first seen.
- R8: `ld_grant` is never 1 while `mem_valid` is 1, so a refill waits for an outstanding eviction or purge write to finish.
- R9: A load with `ld_dc_hit`=1 changes no buffer content, produces no memory write and no `ld_grant`.
- R10: `st_ready` is 0 while a memory write is outstanding, during a purge or grant, and while a data-cache miss load is presented. If both a store and a miss load are presented, the load is handled first. While `mem_ready` is 0, the memory write fields hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store request present |
| st_ready | output | 1 | Store accepted this cycle when high with st_valid |
| st_addr | input | AW | Store byte address; bits [2:0] ignored |
| st_data | input | DW | Store data word |
| st_be | input | DW/8 | Store byte enables |
| ld_valid | input | 1 | Load request present, held until granted |
| ld_dc_hit | input | 1 | 1 when the load hit the data cache |
| ld_addr | input | AW | Load byte address; bits [2:0] ignored |
| ld_grant | output | 1 | One-cycle permission to start the cache refill |
| mem_valid | output | 1 | Memory write pending |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | AW | Aligned address of the written word |
| mem_data | output | DW | Written word |
| mem_be | output | DW/8 | Byte mask of the written word |

## Verification
The interesting collision is a store and a data-cache-miss load presented in the same cycle. The load wins and the store is held off until after the grant. This is provoked by launching a store to a new word and a miss load that matches a held word from one clock edge, with the buffer full. The result is judged through the purge stream: it must contain exactly the previously held words, with the new store absent. The store must then land in an empty buffer without any memory write. A second overlap, an eviction write still in flight when a miss load arrives, is provoked by back-to-back stimulus under random `mem_ready` stalls. It is judged by requiring that no expected write remains outstanding when `ld_grant` is seen.

// File: rtl/wbm_pkg.sv
package wbm_pkg;
  typedef enum logic [1:0] {
    WB_IDLE  = 2'd0,
    WB_EVICT = 2'd1,
    WB_PURGE = 2'd2,
    WB_GRANT = 2'd3
  } wb_state_e;
endpackage

// File: rtl/wbm_match.sv
// Parallel aligned-address compare against every held word.
module wbm_match #(
  parameter int NE = 8,
  parameter int TW = 29
) (
  input  logic [NE-1:0] vld_i,
  input  logic [TW-1:0] tag_i [NE],
  input  logic [TW-1:0] qtag_i,
  output logic [NE-1:0] hit_o
);
  for (genvar g = 0; g < NE; g++) begin : g_cmp
    assign hit_o[g] = vld_i[g] && (tag_i[g] == qtag_i);
  end
endmodule

// File: rtl/wbm_lru.sv
// Recency list: position 0 is least recent, position NE-1 is most recent.
module wbm_lru #(
  parameter int NE = 8,
  parameter int IW = $clog2(NE)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          touch_i,
  input  logic [IW-1:0] tidx_i,
  output logic [IW-1:0] order_o [NE]
);
  logic [IW-1:0] ord_q [NE];
  logic [IW-1:0] nxt   [NE];
  logic [IW-1:0] pos;
  logic [NE-1:0] seen;

  always_comb begin
    pos = '0;
    for (int p = 0; p < NE; p++)
      if (ord_q[p] == tidx_i) pos = IW'(p);
    for (int p = 0; p < NE; p++) begin
      if (p < int'(pos))   nxt[p] = ord_q[p];
      else if (p < NE - 1) nxt[p] = ord_q[(p < NE - 1) ? p + 1 : p];
      else                 nxt[p] = tidx_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < NE; p++) ord_q[p] <= IW'(p);
    end else if (touch_i) begin
      for (int p = 0; p < NE; p++) ord_q[p] <= nxt[p];
    end
  end

  assign order_o = ord_q;

  always_comb begin
    seen = '0;
    for (int p = 0; p < NE; p++) seen[ord_q[p]] = 1'b1;
  end

  // R5: the list always names every slot exactly once
  p_order_perm_r5: assert property (@(posedge clk) disable iff (rst)
    seen == {NE{1'b1}});
endmodule

// File: rtl/wb_merge_lru.sv
module wb_merge_lru
  import wbm_pkg::*;
#(
  parameter int NE = 8,
  parameter int AW = 32,
  parameter int DW = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            st_valid,
  output logic            st_ready,
  input  logic [AW-1:0]   st_addr,
  input  logic [DW-1:0]   st_data,
  input  logic [DW/8-1:0] st_be,
  input  logic            ld_valid,
  input  logic            ld_dc_hit,
  input  logic [AW-1:0]   ld_addr,
  output logic            ld_grant,
  output logic            mem_valid,
  input  logic            mem_ready,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_data,
  output logic [DW/8-1:0] mem_be
);
  localparam int BW = DW / 8;
  localparam int OW = $clog2(BW);
  localparam int TW = AW - OW;
  localparam int IW = $clog2(NE);

  wb_state_e     state_q;
  logic [NE-1:0] vld_q;
  logic [TW-1:0] tag_q [NE];
  logic [DW-1:0] dat_q [NE];
  logic [BW-1:0] be_q  [NE];
  logic          mem_valid_q;
  logic [AW-1:0] mem_addr_q;
  logic [DW-1:0] mem_data_q;
  logic [BW-1:0] mem_be_q;

  logic [TW-1:0] st_tag, ld_tag;
  logic [NE-1:0] st_hv, ld_hv;
  logic          st_hit, ld_hit, ld_miss, st_fire;
  logic [IW-1:0] st_hidx, lru_idx, free_idx, tidx;
  logic          any_vld, any_free;
  logic [IW-1:0] order [NE];
  logic [DW-1:0] base, wdat;
  logic [BW-1:0] wbe;
  logic          unused_lo;

  assign st_tag    = st_addr[AW-1:OW];
  assign ld_tag    = ld_addr[AW-1:OW];
  assign unused_lo = ^{st_addr[OW-1:0], ld_addr[OW-1:0]};

  wbm_match #(.NE(NE), .TW(TW)) u_st_match (
    .vld_i(vld_q), .tag_i(tag_q), .qtag_i(st_tag), .hit_o(st_hv));
  wbm_match #(.NE(NE), .TW(TW)) u_ld_match (
    .vld_i(vld_q), .tag_i(tag_q), .qtag_i(ld_tag), .hit_o(ld_hv));

  assign st_hit  = |st_hv;
  assign ld_hit  = |ld_hv;
  assign ld_miss = ld_valid && !ld_dc_hit;

  always_comb begin
    st_hidx = '0;
    for (int i = 0; i < NE; i++)
      if (st_hv[i]) st_hidx = IW'(i);
  end

  // oldest held slot and oldest free slot, scanning from the least recent end
  always_comb begin
    lru_idx  = order[0];
    free_idx = order[0];
    any_vld  = 1'b0;
    any_free = 1'b0;
    for (int p = NE - 1; p >= 0; p--) begin
      if (vld_q[order[p]])  begin lru_idx  = order[p]; any_vld  = 1'b1; end
      if (!vld_q[order[p]]) begin free_idx = order[p]; any_free = 1'b1; end
    end
  end

  assign st_ready = (state_q == WB_IDLE) && !ld_miss;
  assign st_fire  = st_valid && st_ready;
  assign tidx     = st_hit ? st_hidx : (any_free ? free_idx : lru_idx);

  always_comb begin
    base = st_hit ? dat_q[st_hidx] : '0;
    for (int b = 0; b < BW; b++)
      wdat[b*8 +: 8] = st_be[b] ? st_data[b*8 +: 8] : base[b*8 +: 8];
    wbe = (st_hit ? be_q[st_hidx] : '0) | st_be;
  end

  wbm_lru #(.NE(NE), .IW(IW)) u_lru (
    .clk(clk), .rst(rst), .touch_i(st_fire), .tidx_i(tidx), .order_o(order));

  // entry storage: one write port, addressed by tidx
  always_ff @(posedge clk) begin
    if (st_fire) begin
      tag_q[tidx] <= st_tag;
      dat_q[tidx] <= wdat;
      be_q[tidx]  <= wbe;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= WB_IDLE;
      vld_q       <= '0;
      mem_valid_q <= 1'b0;
      mem_addr_q  <= '0;
      mem_data_q  <= '0;
      mem_be_q    <= '0;
    end else begin
      case (state_q)
        WB_IDLE: begin
          if (ld_miss) begin
            state_q <= ld_hit ? WB_PURGE : WB_GRANT;
          end else if (st_fire) begin
            vld_q[tidx] <= 1'b1;
            if (!st_hit && !any_free) begin
              mem_addr_q  <= {tag_q[lru_idx], OW'(0)};
              mem_data_q  <= dat_q[lru_idx];
              mem_be_q    <= be_q[lru_idx];
              mem_valid_q <= 1'b1;
              state_q     <= WB_EVICT;
            end
          end
        end
        WB_EVICT: begin
          if (mem_ready) begin
            mem_valid_q <= 1'b0;
            state_q     <= WB_IDLE;
          end
        end
        WB_PURGE: begin
          if (mem_valid_q) begin
            if (mem_ready) mem_valid_q <= 1'b0;
          end else if (any_vld) begin
            mem_addr_q     <= {tag_q[lru_idx], OW'(0)};
            mem_data_q     <= dat_q[lru_idx];
            mem_be_q       <= be_q[lru_idx];
            mem_valid_q    <= 1'b1;
            vld_q[lru_idx] <= 1'b0;
          end else begin
            state_q <= WB_GRANT;
          end
        end
        default: state_q <= WB_IDLE;
      endcase
    end
  end

  assign ld_grant  = (state_q == WB_GRANT);
  assign mem_valid = mem_valid_q;
  assign mem_addr  = mem_addr_q;
  assign mem_data  = mem_data_q;
  assign mem_be    = mem_be_q;

  // R2: a word is held in at most one slot
  p_unique_tag_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(st_hv));
  // R6: a grant that follows a purge finds the buffer empty
  p_purge_empty_r6: assert property (@(posedge clk) disable iff (rst)
    (ld_grant && $past(state_q) == WB_PURGE) |-> (vld_q == '0));
  // R7: the grant lasts one cycle
  p_grant_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    ld_grant |=> !ld_grant);
  // R8: no refill permission while a write is outstanding
  p_grant_idle_mem_r8: assert property (@(posedge clk) disable iff (rst)
    ld_grant |-> !mem_valid);
  // R9: a cache-hit load leaves the held set alone
  p_dchit_noop_r9: assert property (@(posedge clk) disable iff (rst)
    (state_q == WB_IDLE && ld_valid && ld_dc_hit && !st_valid)
      |=> ($stable(vld_q) && !ld_grant));
  // R10: stores stall behind an outstanding write
  p_stall_busy_r10: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> !st_ready);
  // R10: write fields hold while memory stalls
  p_mem_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
      && $stable(mem_data) && $stable(mem_be)));
endmodule

// File: tb/sim_wb_merge_lru.sv
module sim_wb_merge_lru;
  typedef struct packed {
    logic [28:0] tag;
    logic [63:0] dat;
    logic [7:0]  be;
  } ent_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        st_valid = 1'b0, st_ready;
  logic [31:0] st_addr = '0;
  logic [63:0] st_data = '0;
  logic [7:0]  st_be = '0;
  logic        ld_valid = 1'b0, ld_dc_hit = 1'b0, ld_grant;
  logic [31:0] ld_addr = '0;
  logic        mem_valid, mem_ready = 1'b0;
  logic [31:0] mem_addr;
  logic [63:0] mem_data;
  logic [7:0]  mem_be;

  int checks = 0, fails = 0, wr_cnt = 0;
  logic [31:0] last_addr = '0;
  bit   sink_on = 1'b0;
  ent_t mq[$];
  ent_t exp_q[$];
  string exp_tag[$];

  always #10 clk = ~clk;

  wb_merge_lru u0 (
    .clk(clk), .rst(rst), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
    .ld_valid(ld_valid), .ld_dc_hit(ld_dc_hit), .ld_addr(ld_addr),
    .ld_grant(ld_grant), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_be(mem_be));

  task automatic chk(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // reference model: mq holds words from least to most recently used
  task automatic m_store(logic [28:0] tag, logic [63:0] d, logic [7:0] be);
    int   hit = -1;
    ent_t e;
    foreach (mq[i]) if (mq[i].tag == tag) hit = i;
    if (hit >= 0) begin
      e = mq[hit];
      mq.delete(hit);
    end else begin
      e.tag = tag; e.dat = '0; e.be = '0;
      if (mq.size() == 8) begin
        exp_q.push_back(mq[0]); exp_tag.push_back("R4");
        mq.delete(0);
      end
    end
    for (int b = 0; b < 8; b++) if (be[b]) e.dat[b*8 +: 8] = d[b*8 +: 8];
    e.be = e.be | be;
    mq.push_back(e);
  endtask

  function automatic bit m_load_miss(logic [28:0] tag);
    bit hit = 1'b0;
    foreach (mq[i]) if (mq[i].tag == tag) hit = 1'b1;
    if (hit) begin
      foreach (mq[i]) begin exp_q.push_back(mq[i]); exp_tag.push_back("R6"); end
      mq.delete();
    end
    return hit;
  endfunction

  // memory sink: randomly ready, checks each accepted write against the model
  initial forever begin
    @(negedge clk);
    mem_ready = sink_on && (($urandom % 4) != 0);
    if (mem_valid && mem_ready) begin
      wr_cnt++;
      last_addr = mem_addr;
      chk(!st_ready, "R10", "st_ready during write", {127'd0, st_ready}, 128'd0);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3", "unexpected memory write", {96'd0, mem_addr}, 128'd0);
      end else begin
        chk(mem_addr == {exp_q[0].tag, 3'b000} && mem_data == exp_q[0].dat
            && mem_be == exp_q[0].be, exp_tag[0], "write addr/data/be",
            {mem_addr, mem_data, 24'd0, mem_be},
            {exp_q[0].tag, 3'b000, exp_q[0].dat, 24'd0, exp_q[0].be});
        void'(exp_q.pop_front());
        void'(exp_tag.pop_front());
      end
    end
  end

  task automatic do_store(logic [31:0] a, logic [63:0] d, logic [7:0] be);
    @(negedge clk);
    st_valid = 1'b1; st_addr = a; st_data = d; st_be = be;
    #1;
    while (!st_ready) begin @(negedge clk); #1; end
    m_store(a[31:3], d, be);
    @(negedge clk);
    st_valid = 1'b0;
  endtask

  task automatic wait_quiet();
    while (mem_valid || exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic do_load(logic [31:0] a, bit dchit);
    int n = 0;
    bit busy, hit;
    @(negedge clk);
    ld_valid = 1'b1; ld_dc_hit = dchit; ld_addr = a;
    if (dchit) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        chk(!ld_grant, "R9", "grant on cache-hit load", {127'd0, ld_grant}, 128'd0);
      end
      ld_valid = 1'b0; ld_dc_hit = 1'b0;
      chk(exp_q.size() == 0 && !mem_valid, "R9", "write after cache-hit load",
          {127'd0, mem_valid}, 128'd0);
    end else begin
      busy = mem_valid;
      hit  = m_load_miss(a[31:3]);
      do begin @(negedge clk); n++; end while (!ld_grant && n < 5000);
      chk(ld_grant, "R6", "grant seen", {127'd0, ld_grant}, 128'd1);
      chk(exp_q.size() == 0 && !mem_valid, busy ? "R8" : "R6",
          "writes left at grant", 128'(exp_q.size()), 128'd0);
      if (!busy && !hit)
        chk(n == 1, "R7", "grant latency", 128'(n), 128'd1);
      ld_valid = 1'b0;
      @(negedge clk);
      chk(!ld_grant, "R7", "grant is one cycle", {127'd0, ld_grant}, 128'd0);
    end
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    chk(st_ready, "R1", "st_ready after reset", {127'd0, st_ready}, 128'd1);
    chk(!mem_valid, "R1", "mem_valid after reset", {127'd0, mem_valid}, 128'd0);
    chk(!ld_grant, "R1", "ld_grant after reset", {127'd0, ld_grant}, 128'd0);
    sink_on = 1'b1;

    // R3: eight allocations write nothing
    for (int i = 0; i < 8; i++)
      do_store(32'h1000 + 32'(i * 8), {$urandom, $urandom}, 8'hFF);
    repeat (4) @(negedge clk);
    chk(wr_cnt == 0, "R3", "writes after 8 allocations", 128'(wr_cnt), 128'd0);

    // R2: partial merge into the oldest word, unaligned address bits ignored
    do_store(32'h1005, 64'h1122334455667788, 8'h0F);
    repeat (4) @(negedge clk);
    chk(wr_cnt == 0, "R2", "writes after merge", 128'(wr_cnt), 128'd0);

    // R4/R5: new word evicts 0x1008, not the refreshed 0x1000
    do_store(32'h2000, 64'hA5A5, 8'h03);
    wait_quiet();
    chk(last_addr == 32'h1008, "R5", "evicted address", {96'd0, last_addr}, 128'h1008);

    // R9: cache-hit load to a held word
    do_load(32'h1010, 1'b1);
    // R7: miss load to a word not held
    do_load(32'h9000, 1'b0);

    // R10: store and purge-causing load in the same cycle; load goes first
    fork
      do_store(32'h3000, 64'hDEAD_BEEF, 8'hF0);
      do_load(32'h1018, 1'b0);
    join
    repeat (3) @(negedge clk);
    chk(mq.size() == 1 && exp_q.size() == 0, "R10", "store after purge",
        128'(mq.size()), 128'd1);

    // R8: eviction in flight when a miss load arrives
    for (int i = 0; i < 8; i++) do_store(32'h4000 + 32'(i * 8), {$urandom, $urandom}, 8'hFF);
    do_load(32'h9100, 1'b0);
    do_load(32'h4038, 1'b0);

    // random mix
    for (int k = 0; k < 400; k++) begin
      int op = $urandom % 20;
      logic [31:0] a = 32'h5000 + 32'(($urandom % 12) * 8) + 32'($urandom % 8);
      if (op < 14) do_store(a, {$urandom, $urandom}, 8'($urandom));
      else if (op < 18) do_load(32'h5000 + 32'(($urandom % 16) * 8), 1'b0);
      else begin wait_quiet(); do_load(a, 1'b1); end
    end
    if (mq.size() != 0) do_load({mq[0].tag, 3'b000}, 1'b0);
    wait_quiet();
    chk(exp_q.size() == 0, "R6", "final drain", 128'(exp_q.size()), 128'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule